// File: doc/BRIEF.md
# Oversampled Gate-Signal Edge Timestamper

This block watches a set of asynchronous gate-drive inputs on a fast sampling clock while a slow step strobe marks the boundaries of simulation steps. For every step it produces one record: the channel levels, and for each channel group a count of fast-clock cycles from the step strobe to the group's first transition, a flag for a step with no change, and a flag for extra transitions that could not be timed. A downstream solver uses the count to correct for where inside the step a switching event really happened.

The channels are split into groups of equal size, and each group carries a single timestamp per step. In oversampling mode the record of a step is handed out at the close of the following step, leaving the solver a full step for the correction. In bypass mode the inputs are read only at the strobe edge, the record appears at the close of the current step and it carries no timing. The ratio of fast-clock cycles to step length is a parameter (50 by default).

Top module: `gts_stamp`

## Requirements
- R1: While reset is held and until the first record, `rec_valid_o` is low and every record output is zero.
- R2: The strobe is counted on the rising edge at which `step_i` is sampled high (edge E). `rec_valid_o` rises for exactly one cycle after edge E+2. The record outputs change only on that edge and hold their value until the next pulse.
- R3: In oversampling mode, the timestamp of group g is `rec_ts_o[g*TS_W +: TS_W]`, with TS_W = ceil(log2(ratio)). It equals the number of rising edges from the strobe edge E to the edge at which the group's new level was first sampled. Edge E itself counts as 0.
- R4: A transition sampled on the strobe edge belongs to the step that the strobe opens, with timestamp 0. A transition sampled on the last edge before the next strobe belongs to the step that is closing.
- R5: A group with no transition in a step reports `rec_nochg_o[g]` = 1 and a timestamp of zero.
- R6: A second transition of a group at a later edge of the same step sets `rec_ovf_o[g]` and leaves the first timestamp in place. Channels of one group that change on the same edge count as one transition.
- R7: In oversampling mode, the level field (bit c = channel c, where group g owns channels g*CH_PER_GROUP to g*CH_PER_GROUP+CH_PER_GROUP-1) holds the inputs sampled on the last edge before the next strobe.
- R8: When `os_en_i` is high at the emitting edge, the record emitted is the one for the step before the step that has just closed. This is one step later than bypass mode.
- R9: When `os_en_i` is low at the emitting edge, the level field holds the inputs sampled at the strobe edge itself and all timestamps and overflow flags are zero. `rec_nochg_o[g]` is 1 when the group's sampled levels equal those sampled at the previous strobe (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle step strobe, synchronous to clk_i |
| os_en_i | input | 1 | 1 = oversampling mode, 0 = bypass mode |
| gate_i | input | NUM_GROUPS*CH_PER_GROUP | Asynchronous gate-drive inputs |
| rec_valid_o | output | 1 | One-cycle pulse marking a new record |
| rec_level_o | output | NUM_GROUPS*CH_PER_GROUP | Channel levels of the record |
| rec_ts_o | output | NUM_GROUPS*TS_W | Per-group timestamps in fast-clock cycles |
| rec_nochg_o | output | NUM_GROUPS | Per-group no-transition flag |
| rec_ovf_o | output | NUM_GROUPS | Per-group extra-transition flag |

## Verification
On every cycle the assertions check the shape of the output handshake. The valid pulse lasts one cycle and follows a strobe by exactly three edges, and the record never moves between pulses. They also check the field consistency that holds in any mode: a quiet group has a zero timestamp, an overflowing group is never quiet, and a bypass record carries no timing or overflow. The numeric timestamps, the assignment of boundary edges to the right step, the level chosen in each mode and the one-step delay of oversampling can only be shown by the bench's scenarios. There, edges placed at known offsets are compared with a step-by-step model.

// File: rtl/gts_pkg.sv
`timescale 1ns/1ps
package gts_pkg;

    typedef enum logic {
        GTS_BYPASS     = 1'b0,
        GTS_OVERSAMPLE = 1'b1
    } gts_mode_e;

    function automatic gts_mode_e gts_mode(input logic os_en);
        return os_en ? GTS_OVERSAMPLE : GTS_BYPASS;
    endfunction

endpackage

// File: rtl/gts_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer followed by a one-sample history register.
module gts_sync #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] hist;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = async_i;
        d.s2   = q.s1;
        d.hist = q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign sync_o = q.s2;
    assign prev_o = q.hist;

endmodule

// File: rtl/gts_phase.sv
`timescale 1ns/1ps
// Step strobe delayed to line up with the synchronizer, plus the
// sub-step cycle counter that produces the timestamp of this edge.
module gts_phase #(
    parameter int TS_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            step_i,
    output logic            close_o,
    output logic [TS_W-1:0] ts_now_o
);

    localparam logic [TS_W-1:0] TS_MAX = '1;

    typedef struct packed {
        logic            p1;
        logic            p2;
        logic [TS_W-1:0] cnt;
    } phase_t;

    phase_t q, d;

    always_comb begin
        d    = q;
        d.p1 = step_i;
        d.p2 = q.p1;
        if (q.p2)
            d.cnt = '0;
        else if (q.cnt != TS_MAX)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign close_o  = q.p2;
    assign ts_now_o = q.p2 ? '0 : ((q.cnt == TS_MAX) ? q.cnt : q.cnt + 1'b1);

endmodule

// File: rtl/gts_group_acc.sv
`timescale 1ns/1ps
// Per-group collector: first edge time, seen flag and overflow flag.
module gts_group_acc #(
    parameter int TS_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            close_i,
    input  logic            det_i,
    input  logic [TS_W-1:0] ts_now_i,
    output logic            seen_o,
    output logic [TS_W-1:0] ts_o,
    output logic            ovf_o
);

    typedef struct packed {
        logic            seen;
        logic [TS_W-1:0] ts;
        logic            ovf;
    } acc_t;

    acc_t q, d;

    always_comb begin
        d = q;
        if (close_i) begin
            d.seen = det_i;
            d.ts   = det_i ? ts_now_i : '0;
            d.ovf  = 1'b0;
        end else if (det_i) begin
            if (q.seen) begin
                d.ovf = 1'b1;
            end else begin
                d.seen = 1'b1;
                d.ts   = ts_now_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign seen_o = q.seen;
    assign ts_o   = q.ts;
    assign ovf_o  = q.ovf;

endmodule

// File: rtl/gts_stamp.sv
`timescale 1ns/1ps
module gts_stamp #(
    parameter int NUM_GROUPS   = 2,
    parameter int CH_PER_GROUP = 2,
    parameter int STEP_RATIO   = 50
) (
    input  logic                                         clk_i,
    input  logic                                         rst_ni,
    input  logic                                         step_i,
    input  logic                                         os_en_i,
    input  logic [NUM_GROUPS*CH_PER_GROUP-1:0]           gate_i,
    output logic                                         rec_valid_o,
    output logic [NUM_GROUPS*CH_PER_GROUP-1:0]           rec_level_o,
    output logic [NUM_GROUPS*((STEP_RATIO > 1) ? $clog2(STEP_RATIO) : 1)-1:0] rec_ts_o,
    output logic [NUM_GROUPS-1:0]                        rec_nochg_o,
    output logic [NUM_GROUPS-1:0]                        rec_ovf_o
);

    import gts_pkg::*;

    localparam int NUM_CH = NUM_GROUPS * CH_PER_GROUP;
    localparam int TS_W   = (STEP_RATIO > 1) ? $clog2(STEP_RATIO) : 1;
    localparam int TSV_W  = NUM_GROUPS * TS_W;

    logic [NUM_CH-1:0]     sync_lvl;
    logic [NUM_CH-1:0]     prev_lvl;
    logic                  close;
    logic [TS_W-1:0]       ts_now;
    logic [NUM_GROUPS-1:0] grp_det;
    logic [NUM_GROUPS-1:0] grp_seen;
    logic [NUM_GROUPS-1:0] grp_ovf;
    logic [TSV_W-1:0]      grp_ts;
    logic [NUM_GROUPS-1:0] bp_same;

    gts_sync #(.W(NUM_CH)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (gate_i),
        .sync_o  (sync_lvl),
        .prev_o  (prev_lvl)
    );

    gts_phase #(.TS_W(TS_W)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step_i),
        .close_o  (close),
        .ts_now_o (ts_now)
    );

    typedef struct packed {
        logic                  valid;
        logic [NUM_CH-1:0]     lvl;
        logic [TSV_W-1:0]      ts;
        logic [NUM_GROUPS-1:0] nc;
        logic [NUM_GROUPS-1:0] ov;
        logic [NUM_CH-1:0]     h_lvl;
        logic [TSV_W-1:0]      h_ts;
        logic [NUM_GROUPS-1:0] h_nc;
        logic [NUM_GROUPS-1:0] h_ov;
        logic [NUM_CH-1:0]     bp_lvl;
    } rec_t;

    rec_t q, d;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_det[g] = |(sync_lvl[g*CH_PER_GROUP +: CH_PER_GROUP]
                            ^ prev_lvl[g*CH_PER_GROUP +: CH_PER_GROUP]);
        assign bp_same[g] = (sync_lvl[g*CH_PER_GROUP +: CH_PER_GROUP]
                            == q.bp_lvl[g*CH_PER_GROUP +: CH_PER_GROUP]);

        gts_group_acc #(.TS_W(TS_W)) u_acc (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .close_i  (close),
            .det_i    (grp_det[g]),
            .ts_now_i (ts_now),
            .seen_o   (grp_seen[g]),
            .ts_o     (grp_ts[g*TS_W +: TS_W]),
            .ovf_o    (grp_ovf[g])
        );
    end

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (close) begin
            d.valid  = 1'b1;
            d.h_lvl  = prev_lvl;
            d.h_ts   = grp_ts;
            d.h_nc   = ~grp_seen;
            d.h_ov   = grp_ovf;
            d.bp_lvl = sync_lvl;
            if (gts_mode(os_en_i) == GTS_OVERSAMPLE) begin
                d.lvl = q.h_lvl;
                d.ts  = q.h_ts;
                d.nc  = q.h_nc;
                d.ov  = q.h_ov;
            end else begin
                d.lvl = sync_lvl;
                d.ts  = '0;
                d.nc  = bp_same;
                d.ov  = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.h_nc <= '1;
        end else begin
            q <= d;
        end
    end

    assign rec_valid_o = q.valid;
    assign rec_level_o = q.lvl;
    assign rec_ts_o    = q.ts;
    assign rec_nochg_o = q.nc;
    assign rec_ovf_o   = q.ov;

endmodule

// File: rtl/gts_stamp_chk.sv
`timescale 1ns/1ps
module gts_stamp_chk #(
    parameter int NUM_GROUPS   = 2,
    parameter int CH_PER_GROUP = 2,
    parameter int TS_W         = 6
) (
    input logic                                 clk_i,
    input logic                                 rst_ni,
    input logic                                 step_i,
    input logic                                 os_en_i,
    input logic                                 rec_valid_o,
    input logic [NUM_GROUPS*CH_PER_GROUP-1:0]   rec_level_o,
    input logic [NUM_GROUPS*TS_W-1:0]           rec_ts_o,
    input logic [NUM_GROUPS-1:0]                rec_nochg_o,
    input logic [NUM_GROUPS-1:0]                rec_ovf_o
);

    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_valid_o |=> !rec_valid_o);

    assert_pulse_follows_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_valid_o |-> $past(step_i, 3));

    assert_record_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rec_valid_o |-> ($stable(rec_level_o) && $stable(rec_ts_o)
                          && $stable(rec_nochg_o) && $stable(rec_ovf_o)));

    assert_bypass_untimed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rec_valid_o && !$past(os_en_i)) |-> (rec_ts_o == '0 && rec_ovf_o == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        assert_quiet_zero_ts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rec_nochg_o[g] |-> (rec_ts_o[g*TS_W +: TS_W] == '0));

        assert_overflow_not_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rec_ovf_o[g] |-> !rec_nochg_o[g]);
    end

endmodule

bind gts_stamp gts_stamp_chk #(
    .NUM_GROUPS   (NUM_GROUPS),
    .CH_PER_GROUP (CH_PER_GROUP),
    .TS_W         (TS_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .os_en_i     (os_en_i),
    .rec_valid_o (rec_valid_o),
    .rec_level_o (rec_level_o),
    .rec_ts_o    (rec_ts_o),
    .rec_nochg_o (rec_nochg_o),
    .rec_ovf_o   (rec_ovf_o)
);

// File: tb/tb_gts_stamp.sv
`timescale 1ns/1ps
module tb_gts_stamp;

    localparam int NG   = 2;
    localparam int CPG  = 2;
    localparam int NCH  = NG * CPG;
    localparam int R    = 50;
    localparam int TSW  = $clog2(R);
    localparam int NV   = 11;
    localparam int NONE = 63;

    // vector: [20] os_en, [19:16] toggle mask A, [15:10] offset A,
    //         [9:6] toggle mask B, [5:0] offset B (63 = no toggle)
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'b0001, 6'd10, 4'b0000, 6'd63},
        {1'b0, 4'b0100, 6'd0,  4'b1000, 6'd20},
        {1'b0, 4'b0010, 6'd5,  4'b0010, 6'd30},
        {1'b1, 4'b0001, 6'd7,  4'b1100, 6'd49},
        {1'b1, 4'b0011, 6'd12, 4'b0000, 6'd63},
        {1'b1, 4'b0100, 6'd3,  4'b0100, 6'd40},
        {1'b1, 4'b0010, 6'd0,  4'b1000, 6'd25},
        {1'b1, 4'b0000, 6'd63, 4'b0000, 6'd63},
        {1'b1, 4'b0000, 6'd63, 4'b0000, 6'd63},
        {1'b0, 4'b0001, 6'd9,  4'b0000, 6'd63},
        {1'b0, 4'b0000, 6'd63, 4'b0000, 6'd63}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step = 1'b0;
    logic            os_en = 1'b0;
    logic [NCH-1:0]  gate = '0;
    logic            valid;
    logic [NCH-1:0]  lvl;
    logic [NG*TSW-1:0] ts;
    logic [NG-1:0]   nc;
    logic [NG-1:0]   ov;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gts_stamp #(.NUM_GROUPS(NG), .CH_PER_GROUP(CPG), .STEP_RATIO(R)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .step_i      (step),
        .os_en_i     (os_en),
        .gate_i      (gate),
        .rec_valid_o (valid),
        .rec_level_o (lvl),
        .rec_ts_o    (ts),
        .rec_nochg_o (nc),
        .rec_ovf_o   (ov)
    );

    // model storage: step k record at index k+2, indices 0 and 1 quiet
    logic [NCH-1:0]    m_lvl [NV+2];
    logic [NG*TSW-1:0] m_ts  [NV+2];
    logic [NG-1:0]     m_nc  [NV+2];
    logic [NG-1:0]     m_ov  [NV+2];
    logic [NCH-1:0]    e_lvl [NV];
    logic [NG*TSW-1:0] e_ts  [NV];
    logic [NG-1:0]     e_nc  [NV];
    logic [NG-1:0]     e_ov  [NV];
    bit                e_os  [NV];

    logic [NCH-1:0]    prev_bp = '0;
    logic [NCH-1:0]    held_lvl = '0;
    logic [NG*TSW-1:0] held_ts = '0;
    logic [NG-1:0]     held_nc = '0;
    logic [NG-1:0]     held_ov = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_zero(input string req);
        chk(valid == 1'b0, req, 32'(valid), 32'd0);
        chk(lvl == '0 && ts == '0 && nc == '0 && ov == '0, req,
            {lvl, ts, nc, ov}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_lvl[i] = '0; m_ts[i] = '0; m_nc[i] = '1; m_ov[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        check_zero("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check_zero("R1 after reset");
        end

        for (int k = 0; k < NV; k++) begin
            logic [3:0] ma, mb;
            int oa, ob;
            ma = VEC[k][19:16]; oa = int'(VEC[k][15:10]);
            mb = VEC[k][9:6];   ob = int'(VEC[k][5:0]);
            for (int j = 0; j < R; j++) begin
                @(negedge clk);
                step = (j == 0);
                if (j == 0) os_en = VEC[k][20];
                if (j == oa) gate = gate ^ ma;
                if (j == ob) gate = gate ^ mb;
                if (j == 0) begin
                    e_os[k] = VEC[k][20];
                    if (VEC[k][20]) begin
                        e_lvl[k] = m_lvl[k]; e_ts[k] = m_ts[k];
                        e_nc[k]  = m_nc[k];  e_ov[k] = m_ov[k];
                    end else begin
                        e_lvl[k] = gate; e_ts[k] = '0; e_ov[k] = '0;
                        for (int g = 0; g < NG; g++)
                            e_nc[k][g] = (gate[g*CPG +: CPG] == prev_bp[g*CPG +: CPG]);
                    end
                    prev_bp = gate;
                end
                if (j == R - 1) begin
                    m_lvl[k+2] = gate;
                    for (int g = 0; g < NG; g++) begin
                        bit ha, hb;
                        ha = (ma[g*CPG +: CPG] != '0) && (oa < R);
                        hb = (mb[g*CPG +: CPG] != '0) && (ob < R);
                        m_ov[k+2][g] = ha && hb && (oa != ob);
                        m_nc[k+2][g] = !(ha || hb);
                        if (ha && hb)
                            m_ts[k+2][g*TSW +: TSW] = TSW'((oa < ob) ? oa : ob);
                        else if (ha)
                            m_ts[k+2][g*TSW +: TSW] = TSW'(oa);
                        else if (hb)
                            m_ts[k+2][g*TSW +: TSW] = TSW'(ob);
                        else
                            m_ts[k+2][g*TSW +: TSW] = '0;
                    end
                end
                @(posedge clk); #1;
                chk(valid == (j == 2), "R2 pulse timing", 32'(valid), 32'(j == 2));
                if (j == 2) begin
                    // R8: in oversampling steps the expectation is the record
                    // two steps back from the strobe that is emitting
                    chk(lvl == e_lvl[k], e_os[k] ? "R7 R8 level" : "R9 level",
                        32'(lvl), 32'(e_lvl[k]));
                    // R4: vectors 1,3,6 put edges on strobe edges and the last edge
                    chk(ts == e_ts[k], e_os[k] ? "R3 R4 timestamp" : "R9 timestamp",
                        32'(ts), 32'(e_ts[k]));
                    chk(nc == e_nc[k], e_os[k] ? "R5 no-change" : "R9 no-change",
                        32'(nc), 32'(e_nc[k]));
                    chk(ov == e_ov[k], e_os[k] ? "R6 overflow" : "R9 overflow",
                        32'(ov), 32'(e_ov[k]));
                    held_lvl = lvl; held_ts = ts; held_nc = nc; held_ov = ov;
                end else if (j == R - 1) begin
                    chk(lvl == held_lvl && ts == held_ts && nc == held_nc && ov == held_ov,
                        "R2 record held", {lvl, ts, nc, ov},
                        {held_lvl, held_ts, held_nc, held_ov});
                end
            end
        end

        // directed: strobe-less idle keeps record and gives no pulse (R2)
        @(negedge clk);
        step = 1'b0;
        gate = gate ^ 4'b1111;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            chk(valid == 1'b0, "R2 no pulse without strobe", 32'(valid), 32'd0);
        end
        chk(lvl == held_lvl && nc == held_nc, "R2 record held while idle",
            {lvl, nc}, {held_lvl, held_nc});

        // directed: reset in mid-run clears the record (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_zero("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule